// File: doc/BRIEF.md
# Multi-Channel Digital Silence Flag

This block watches six channels of parallel audio samples that arrive together under one frame strobe. It drives an active-low flag once every channel that takes part in the check has carried nothing but all-zero samples for 9600 frames in a row. Downstream logic can use the flag to mute outputs or pause recording while no programme material is present.

Each channel has a participation bit, so a channel that is known to be unused, or that carries a constant offset, can be left out of the decision. A pin-strap input overrides the mask and makes all six channels take part. A mute input drives the flag active at once, whatever the data holds. A change to the set of taking-part channels starts the count from zero again.

Top module: `sd_silence_detect`

## Requirements
- R1: `silent_n` goes low in the cycle after the clock edge that takes in the 9600th consecutive frame (`frame_vld` high) in which every participating channel is exactly zero, and it stays high after only 9599 such frames.
- R2: A frame with any non-zero sample on a participating channel restarts the run, and `silent_n` is high in the cycle after that edge. A fresh run of 9600 zero frames is then needed before the flag drops again.
- R3: The run count saturates at 9600. The flag stays low for as long as the zero frames continue, including well beyond 16384 frames.
- R4: While `mute` is high, `silent_n` is low in the same cycle, whatever the sample values. When `mute` is released, the flag returns to the value the silence run alone gives.
- R5: Channel i is carried in `samples[i*24 +: 24]`, and `part_mask[i]` = 1 makes it take part. A channel whose mask bit is 0 is ignored, even if it carries non-zero data.
- R6: While `strap_all` is high, all six channels take part, whatever `part_mask` holds.
- R7: When no channel takes part (`strap_all` = 0 and `part_mask` = 0) and `mute` is low, `silent_n` stays high however long the zero frames continue.
- R8: Any change to the effective participation set restarts the count, so 9600 further zero frames are needed after the change.
- R9: Only cycles with `frame_vld` high are counted. Idle cycles neither advance the run nor break it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_vld | input | 1 | Strobe: one new sample per channel in this cycle |
| samples | input | 144 | Six 24-bit samples, channel i at bits i*24 +: 24 |
| part_mask | input | 6 | Participation bit per channel |
| strap_all | input | 1 | Pin-strap mode: all channels take part |
| mute | input | 1 | Digital mute: forces the flag active |
| silent_n | output | 1 | Active-low silence flag |

## Verification
The hardest case to reach from the ports is saturation. A wrapping counter only shows a fault after 16384 zero frames, so the bench strobes a frame on every clock and keeps a run going for more than 17000 frames. It checks that the flag is still low at the end. The boundary at 9600 frames is probed from both sides: at 9599 frames, after a restart caused by a mask change, and after an idle gap that sits in the middle of a run.

// File: rtl/sd_pkg.sv
package sd_pkg;

    localparam int unsigned SD_NUM_CH   = 6;
    localparam int unsigned SD_SAMPLE_W = 24;
    localparam int unsigned SD_RUN_LEN  = 9600;

    // Per-frame instruction to the run counter
    typedef struct packed {
        logic restart;   // participation set changed
        logic clear;     // participating channel carried non-zero data
        logic advance;   // a clean all-zero frame arrived
        logic inhibit;   // nothing participates: flag may not assert
    } run_ctrl_t;

    function automatic logic any_set(input logic [SD_NUM_CH-1:0] v);
        return |v;
    endfunction

endpackage

// File: rtl/sd_chan_zero.sv
module sd_chan_zero #(
    parameter int unsigned SAMPLE_W = 24
) (
    input  logic [SAMPLE_W-1:0] sample,
    input  logic                take_part,
    output logic                breaks_run
);
    // A channel breaks the silence run only when it takes part and carries data
    always_comb begin
        breaks_run = take_part & (|sample);
    end
endmodule

// File: rtl/sd_run_counter.sv
module sd_run_counter
    import sd_pkg::*;
#(
    parameter int unsigned RUN_LEN = 9600
) (
    input  logic      clk,
    input  logic      rst,
    input  run_ctrl_t ctrl,
    output logic      reached
);
    localparam int unsigned CW = $clog2(RUN_LEN + 1);
    localparam logic [CW-1:0] LIMIT = CW'(RUN_LEN);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_d;
    logic          reached_q;

    always_comb begin
        cnt_d = cnt_q;
        if (ctrl.restart || ctrl.clear) begin
            cnt_d = '0;
        end else if (ctrl.advance) begin
            cnt_d = (cnt_q == LIMIT) ? cnt_q : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q     <= '0;
            reached_q <= 1'b0;
        end else begin
            cnt_q     <= cnt_d;
            reached_q <= !ctrl.inhibit && (cnt_d == LIMIT);
        end
    end

    assign reached = reached_q;
endmodule

// File: rtl/sd_silence_detect.sv
module sd_silence_detect
    import sd_pkg::*;
#(
    parameter int unsigned NUM_CH   = SD_NUM_CH,
    parameter int unsigned SAMPLE_W = SD_SAMPLE_W,
    parameter int unsigned RUN_LEN  = SD_RUN_LEN
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         frame_vld,
    input  logic [NUM_CH*SAMPLE_W-1:0]   samples,
    input  logic [NUM_CH-1:0]            part_mask,
    input  logic                         strap_all,
    input  logic                         mute,
    output logic                         silent_n
);
    logic [NUM_CH-1:0] eff_mask;
    logic [NUM_CH-1:0] eff_mask_q;
    logic [NUM_CH-1:0] ch_break;
    run_ctrl_t         ctrl;
    logic              reached;

    // Pin-strap mode makes every channel take part
    assign eff_mask = strap_all ? {NUM_CH{1'b1}} : part_mask;

    always_ff @(posedge clk) begin
        if (rst) begin
            eff_mask_q <= '0;
        end else begin
            eff_mask_q <= eff_mask;
        end
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        sd_chan_zero #(
            .SAMPLE_W (SAMPLE_W)
        ) u_zero (
            .sample     (samples[g*SAMPLE_W +: SAMPLE_W]),
            .take_part  (eff_mask[g]),
            .breaks_run (ch_break[g])
        );
    end

    always_comb begin
        ctrl.restart = (eff_mask != eff_mask_q);
        ctrl.clear   = frame_vld && (|ch_break);
        ctrl.advance = frame_vld && !(|ch_break);
        ctrl.inhibit = !(|eff_mask);
    end

    sd_run_counter #(
        .RUN_LEN (RUN_LEN)
    ) u_run (
        .clk     (clk),
        .rst     (rst),
        .ctrl    (ctrl),
        .reached (reached)
    );

    // Mute acts without a register stage
    assign silent_n = !(mute || reached);
endmodule

// File: rtl/sd_silence_checker.sv
module sd_silence_checker #(
    parameter int unsigned NUM_CH   = 6,
    parameter int unsigned SAMPLE_W = 24
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       frame_vld,
    input logic [NUM_CH*SAMPLE_W-1:0] samples,
    input logic [NUM_CH-1:0]          part_mask,
    input logic                       strap_all,
    input logic                       mute,
    input logic                       silent_n
);
    logic [NUM_CH-1:0] chk_mask;
    logic              chk_dirty;

    always_comb begin
        chk_mask  = strap_all ? {NUM_CH{1'b1}} : part_mask;
        chk_dirty = 1'b0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (chk_mask[i] && (samples[i*SAMPLE_W +: SAMPLE_W] != '0)) chk_dirty = 1'b1;
        end
    end

    AST_MUTE_FORCES: assert property (@(posedge clk) disable iff (rst)
        mute |-> !silent_n);  // R4

    AST_DIRTY_RAISES: assert property (@(posedge clk) disable iff (rst)
        (frame_vld && chk_dirty) |=> (mute || silent_n));  // R2

    AST_EMPTY_SET_HIGH: assert property (@(posedge clk) disable iff (rst)
        (chk_mask == '0) |=> (mute || silent_n));  // R7

    AST_MASK_CHANGE_RESTART: assert property (@(posedge clk) disable iff (rst)
        (chk_mask != $past(chk_mask)) |=> (mute || silent_n));  // R8

    AST_FALL_ON_FRAME: assert property (@(posedge clk) disable iff (rst)
        ($fell(silent_n) && !mute) |-> $past(frame_vld));  // R1
endmodule

bind sd_silence_detect sd_silence_checker #(
    .NUM_CH   (NUM_CH),
    .SAMPLE_W (SAMPLE_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .frame_vld (frame_vld),
    .samples   (samples),
    .part_mask (part_mask),
    .strap_all (strap_all),
    .mute      (mute),
    .silent_n  (silent_n)
);

// File: tb/sd_silence_detect_tb.sv
module sd_silence_detect_tb;
    localparam int NCH = 6;
    localparam int SW  = 24;
    localparam int RUN = 9600;

    logic              clk = 1'b0;
    logic              rst;
    logic              frame_vld;
    logic [NCH*SW-1:0] samples;
    logic [NCH-1:0]    part_mask;
    logic              strap_all;
    logic              mute;
    logic              silent_n;

    int n_checks = 0;
    int n_errors = 0;
    bit done     = 0;

    always #10 clk = ~clk;

    sd_silence_detect u_dut (
        .clk       (clk),
        .rst       (rst),
        .frame_vld (frame_vld),
        .samples   (samples),
        .part_mask (part_mask),
        .strap_all (strap_all),
        .mute      (mute),
        .silent_n  (silent_n)
    );

    task automatic check(input string req, input logic exp);
        n_checks++;
        if (silent_n !== exp) begin
            n_errors++;
            $display("FAIL %s: silent_n actual=%b expected=%b at %0t", req, silent_n, exp, $time);
        end
    endtask

    task automatic set_ch(input int ch, input logic [SW-1:0] v);
        samples[ch*SW +: SW] = v;
    endtask

    // Feed n frames, one per clock; returns at a negedge
    task automatic frames(input int n);
        if (n > 0) begin
            frame_vld = 1'b1;
            repeat (n) @(negedge clk);
            frame_vld = 1'b0;
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; frame_vld = 0; samples = '0; part_mask = '1; strap_all = 0; mute = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 reset", 1'b1);
    endtask

    task automatic t_threshold();
        do_reset();
        frames(RUN - 1);
        check("R1 9599 frames", 1'b1);
        frames(1);
        check("R1 9600 frames", 1'b0);
    endtask

    task automatic t_nonzero();
        set_ch(3, 24'h000001);
        frames(1);
        check("R2 nonzero raises", 1'b1);
        set_ch(3, '0);
        frames(RUN - 1);
        check("R2 rerun 9599", 1'b1);
        frames(1);
        check("R2 rerun 9600", 1'b0);
    endtask

    task automatic t_saturate();
        frames(17000 - RUN);
        check("R3 beyond wrap", 1'b0);
    endtask

    task automatic t_mute();
        do_reset();
        set_ch(0, 24'h7FFFFF);
        mute = 1'b1;
        #1;
        check("R4 mute forces", 1'b0);
        frames(5);
        check("R4 mute with data", 1'b0);
        mute = 1'b0;
        #1;
        check("R4 mute released", 1'b1);
        set_ch(0, '0);
    endtask

    task automatic t_mask();
        do_reset();
        part_mask = 6'b111011;
        @(negedge clk);
        set_ch(2, 24'h123456);
        frames(RUN);
        check("R5 ignored channel", 1'b0);
    endtask

    task automatic t_strap();
        strap_all = 1'b1;
        @(negedge clk);
        frames(RUN + 10);
        check("R6 strap includes masked channel", 1'b1);
        set_ch(2, '0);
        part_mask = '0;
        @(negedge clk);
        frames(RUN);
        check("R6 strap with empty mask", 1'b0);
        strap_all = 1'b0;
    endtask

    task automatic t_empty();
        do_reset();
        part_mask = '0;
        set_ch(4, 24'hABCDEF);
        frames(RUN + 50);
        check("R7 no participants", 1'b1);
        set_ch(4, '0);
    endtask

    task automatic t_mask_change();
        do_reset();
        frames(5000);
        part_mask = 6'b000111;
        @(negedge clk);
        frames(5000);
        check("R8 restart after change", 1'b1);
        frames(RUN - 5000 - 1);
        check("R8 9599 after change", 1'b1);
        frames(1);
        check("R8 9600 after change", 1'b0);
    endtask

    task automatic t_idle();
        do_reset();
        frames(RUN - 1);
        repeat (100) @(negedge clk);
        check("R9 idle not counted", 1'b1);
        frames(1);
        check("R9 run survives idle", 1'b0);
    endtask

    initial begin
        t_reset();
        t_threshold();
        t_nonzero();
        t_threshold();
        t_saturate();
        t_mute();
        t_mask();
        t_strap();
        t_empty();
        t_mask_change();
        t_idle();
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule